// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler with Register Scoreboard

This block is the issue stage of a small out-of-order core. Decoded instructions are dispatched into a reservation station with a few slots. Each slot records the opcode, two source registers with ready flags, a destination register and a lifecycle status. A scoreboard holds one availability bit per architectural register. Dispatch clears the bit of the destination register. The bit is set again when the producing instruction finishes and broadcasts its destination. The same broadcast also wakes any waiting slot that names that register as a source.

Each cycle, at most one ready slot is sent to execution, and the oldest ready slot goes first. Execution has a fixed latency per opcode, and the scheduler models it with a countdown in each slot. When the countdown ends, the slot is marked completed and its destination is broadcast. An external retirement stage later commits completed slots by index, and a committed slot becomes free for dispatch again. Operand values and the datapath are outside this block.

Top module: `oo_issue_sched`

## Requirements
- R1: After reset, every slot is free, all scoreboard bits are 1, `dispReady` is 1, `issueValid` is 0 and `wbMask` is 0.
- R2: An accepted dispatch that names a destination clears that register's scoreboard bit from the next cycle. This holds even when the same register is broadcast in the dispatch cycle. A dispatch without a destination leaves the scoreboard unchanged.
- R3: A dispatched instruction whose sources are all available, or absent (used flag 0), issues in the cycle after dispatch, provided no older slot is ready.
- R4: A slot with an unavailable source waits. It issues in the cycle after that register is broadcast. Independent younger instructions may issue ahead of it.
- R5: An instruction issued in cycle t broadcasts its destination on `wbMask` in cycle t+1 for ALU and branch opcodes, and in cycle t+4 for loads. The scoreboard bit reads 1 from the following cycle.
- R6: At most one slot issues per cycle. Among ready slots, the one dispatched earliest is chosen, whatever its slot index.
- R7: `dispReady` is 0 when no slot is free. It is also 0 when the dispatch names a destination whose scoreboard bit is 0 and that register is not being broadcast this cycle. While `dispReady` is 0, `dispValid` has no effect.
- R8: A commit of a slot that has completed frees that slot. A commit of a slot that is still waiting, ready or executing is ignored, and that slot still broadcasts on time.
- R9: A source register that is broadcast in the dispatch cycle counts as available to the dispatched instruction.
- R10: Opcode encoding: 0 is ALU, 1 is load, 2 is branch, and 3 is treated as ALU (latency 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dispValid | input | 1 | Dispatch request |
| dispOp | input | 2 | Opcode of dispatched instruction |
| dispSrcA | input | 3 | First source register |
| dispSrcAUsed | input | 1 | First source present |
| dispSrcB | input | 3 | Second source register |
| dispSrcBUsed | input | 1 | Second source present |
| dispDst | input | 3 | Destination register |
| dispDstUsed | input | 1 | Destination present |
| dispReady | output | 1 | Dispatch can be accepted this cycle |
| issueValid | output | 1 | A slot issues this cycle |
| issueSlot | output | 2 | Index of issuing slot |
| issueOp | output | 2 | Opcode of issuing slot |
| issueDst | output | 3 | Destination of issuing slot |
| issueDstUsed | output | 1 | Issuing slot has a destination |
| wbMask | output | 8 | Registers produced this cycle |
| commitValid | input | 1 | Commit request |
| commitSlot | input | 2 | Slot to commit |
| regAvail | output | 8 | Scoreboard, one bit per register |

## Verification
The bench builds a case in which two waiting consumers wake on the same load and the older one sits in the higher slot index. A design that picks by index instead of by age would issue them in the wrong order. A consumer is dispatched in the exact cycle its producer broadcasts. Without same-cycle forwarding, that consumer would wait forever and never issue. A write-after-write dispatch is held until the in-flight producer broadcasts, and the bench then checks that the new dispatch's clear wins over the simultaneous set. Commits aimed at a still-executing load check that the load is not dropped: a design that freed the slot early would lose its broadcast.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    OP_ALU    = 2'd0,
    OP_LOAD   = 2'd1,
    OP_BRANCH = 2'd2,
    OP_SPARE  = 2'd3
  } opcode_e;

  typedef enum logic [2:0] {
    ST_WAIT    = 3'd0,
    ST_READY   = 3'd1,
    ST_EXEC    = 3'd2,
    ST_DONE    = 3'd3,
    ST_RETIRED = 3'd4
  } status_e;

  typedef struct packed {
    logic dispWe;
    logic issueWe;
    logic commitWe;
  } strobe_t;

endpackage

// File: rtl/sched_entry_array.sv
module sched_entry_array
  import sched_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ENTRIES  = 4,
  parameter int ALU_LAT  = 1,
  parameter int LOAD_LAT = 4
) (
  input  logic                                            clk,
  input  logic                                            rstN,
  input  strobe_t                                         strobe,
  input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] dispSlot,
  input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] issueSlot,
  input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] commitSlot,
  input  logic [1:0]                                      dispOp,
  input  logic [$clog2(NUM_REGS)-1:0]                     dispSrcA,
  input  logic                                            dispSrcAUsed,
  input  logic [$clog2(NUM_REGS)-1:0]                     dispSrcB,
  input  logic                                            dispSrcBUsed,
  input  logic [$clog2(NUM_REGS)-1:0]                     dispDst,
  input  logic                                            dispDstUsed,
  output logic [ENTRIES-1:0]                              readyMask,
  output logic [ENTRIES-1:0]                              freeMask,
  output logic [ENTRIES-1:0][((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] agesPacked,
  output logic [1:0]                                      issueOp,
  output logic [$clog2(NUM_REGS)-1:0]                     issueDst,
  output logic                                            issueDstUsed,
  output logic [NUM_REGS-1:0]                             wbMask,
  output logic [NUM_REGS-1:0]                             regAvail
);

  localparam int RW      = $clog2(NUM_REGS);
  localparam int SW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int AGE_W   = SW;
  localparam int MAX_LAT = (LOAD_LAT > ALU_LAT) ? LOAD_LAT : ALU_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(ENTRIES - 1);

  status_e            st       [ENTRIES];
  opcode_e            opQ      [ENTRIES];
  logic [RW-1:0]      srcAQ    [ENTRIES];
  logic [RW-1:0]      srcBQ    [ENTRIES];
  logic               rdyAQ    [ENTRIES];
  logic               rdyBQ    [ENTRIES];
  logic [RW-1:0]      dstQ     [ENTRIES];
  logic               dstUsedQ [ENTRIES];
  logic [AGE_W-1:0]   ageQ     [ENTRIES];
  logic [CNT_W-1:0]   cntQ     [ENTRIES];
  logic [NUM_REGS-1:0] availQ;

  logic               wakeA    [ENTRIES];
  logic               wakeB    [ENTRIES];
  logic               newRdyA, newRdyB;
  logic [NUM_REGS-1:0] clrMask;

  function automatic logic [CNT_W-1:0] latencyOf(opcode_e o);
    return (o == OP_LOAD) ? CNT_W'(LOAD_LAT - 1) : CNT_W'(ALU_LAT - 1);
  endfunction

  // broadcast of finishing slots and per-slot wakeup
  always_comb begin
    wbMask = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (st[i] == ST_EXEC && cntQ[i] == '0 && dstUsedQ[i]) wbMask[dstQ[i]] = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      wakeA[i] = rdyAQ[i] | wbMask[srcAQ[i]];
      wakeB[i] = rdyBQ[i] | wbMask[srcBQ[i]];
    end
  end

  // readiness of the incoming instruction, forwarding a same-cycle broadcast
  assign newRdyA = !dispSrcAUsed || availQ[dispSrcA] || wbMask[dispSrcA];
  assign newRdyB = !dispSrcBUsed || availQ[dispSrcB] || wbMask[dispSrcB];
  assign clrMask = (strobe.dispWe && dispDstUsed) ? (NUM_REGS'(1) << dispDst) : '0;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      readyMask[i]  = (st[i] == ST_READY);
      freeMask[i]   = (st[i] == ST_RETIRED);
      agesPacked[i] = ageQ[i];
    end
  end

  assign issueOp      = opQ[issueSlot];
  assign issueDst     = dstQ[issueSlot];
  assign issueDstUsed = dstUsedQ[issueSlot];
  assign regAvail     = availQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      availQ <= '1;
      for (int i = 0; i < ENTRIES; i++) begin
        st[i]       <= ST_RETIRED;
        opQ[i]      <= OP_ALU;
        srcAQ[i]    <= '0;
        srcBQ[i]    <= '0;
        rdyAQ[i]    <= 1'b0;
        rdyBQ[i]    <= 1'b0;
        dstQ[i]     <= '0;
        dstUsedQ[i] <= 1'b0;
        ageQ[i]     <= '0;
        cntQ[i]     <= '0;
      end
    end else begin
      // clear from a new dispatch takes precedence over a same-cycle set
      availQ <= (availQ | wbMask) & ~clrMask;
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.dispWe && dispSlot == SW'(i)) begin
          opQ[i]      <= opcode_e'(dispOp);
          srcAQ[i]    <= dispSrcA;
          srcBQ[i]    <= dispSrcB;
          rdyAQ[i]    <= newRdyA;
          rdyBQ[i]    <= newRdyB;
          dstQ[i]     <= dispDst;
          dstUsedQ[i] <= dispDstUsed;
          ageQ[i]     <= '0;
          cntQ[i]     <= '0;
          st[i]       <= (newRdyA && newRdyB) ? ST_READY : ST_WAIT;
        end else begin
          if (strobe.dispWe && st[i] != ST_RETIRED && ageQ[i] != AGE_MAX)
            ageQ[i] <= ageQ[i] + 1'b1;
          unique case (st[i])
            ST_WAIT: begin
              rdyAQ[i] <= wakeA[i];
              rdyBQ[i] <= wakeB[i];
              if (wakeA[i] && wakeB[i]) st[i] <= ST_READY;
            end
            ST_READY: begin
              if (strobe.issueWe && issueSlot == SW'(i)) begin
                st[i]   <= ST_EXEC;
                cntQ[i] <= latencyOf(opQ[i]);
              end
            end
            ST_EXEC: begin
              if (cntQ[i] == '0) st[i] <= ST_DONE;
              else               cntQ[i] <= cntQ[i] - 1'b1;
            end
            ST_DONE: begin
              if (strobe.commitWe && commitSlot == SW'(i)) st[i] <= ST_RETIRED;
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ENTRIES  = 4
) (
  input  logic [ENTRIES-1:0]                              readyMask,
  input  logic [ENTRIES-1:0]                              freeMask,
  input  logic [ENTRIES-1:0][((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] agesPacked,
  input  logic [NUM_REGS-1:0]                             regAvail,
  input  logic [NUM_REGS-1:0]                             wbMask,
  input  logic                                            dispValid,
  input  logic [$clog2(NUM_REGS)-1:0]                     dispDst,
  input  logic                                            dispDstUsed,
  input  logic                                            commitValid,
  output strobe_t                                         strobe,
  output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] dispSlot,
  output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] issueSlot,
  output logic                                            dispReady,
  output logic                                            issueValid
);

  localparam int SW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int AGE_W = SW;

  logic             hasFree;
  logic             wawHazard;
  logic             found;
  logic [AGE_W-1:0] bestAge;

  // lowest free slot receives the next dispatch
  always_comb begin
    hasFree  = 1'b0;
    dispSlot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (freeMask[i]) begin
        hasFree  = 1'b1;
        dispSlot = SW'(i);
      end
    end
  end

  // oldest ready slot wins issue
  always_comb begin
    found     = 1'b0;
    bestAge   = '0;
    issueSlot = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (readyMask[i] && (!found || agesPacked[i] > bestAge)) begin
        found     = 1'b1;
        bestAge   = agesPacked[i];
        issueSlot = SW'(i);
      end
    end
  end

  assign wawHazard  = dispDstUsed && !regAvail[dispDst] && !wbMask[dispDst];
  assign dispReady  = hasFree && !wawHazard;
  assign issueValid = found;

  assign strobe.dispWe   = dispValid && dispReady;
  assign strobe.issueWe  = found;
  assign strobe.commitWe = commitValid;

endmodule

// File: rtl/oo_issue_sched.sv
module oo_issue_sched
  import sched_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ENTRIES  = 4,
  parameter int ALU_LAT  = 1,
  parameter int LOAD_LAT = 4
) (
  input  logic                                            clk,
  input  logic                                            rstN,
  input  logic                                            dispValid,
  input  logic [1:0]                                      dispOp,
  input  logic [$clog2(NUM_REGS)-1:0]                     dispSrcA,
  input  logic                                            dispSrcAUsed,
  input  logic [$clog2(NUM_REGS)-1:0]                     dispSrcB,
  input  logic                                            dispSrcBUsed,
  input  logic [$clog2(NUM_REGS)-1:0]                     dispDst,
  input  logic                                            dispDstUsed,
  output logic                                            dispReady,
  output logic                                            issueValid,
  output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] issueSlot,
  output logic [1:0]                                      issueOp,
  output logic [$clog2(NUM_REGS)-1:0]                     issueDst,
  output logic                                            issueDstUsed,
  output logic [NUM_REGS-1:0]                             wbMask,
  input  logic                                            commitValid,
  input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] commitSlot,
  output logic [NUM_REGS-1:0]                             regAvail
);

  localparam int SW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  strobe_t                        strobe;
  logic [SW-1:0]                  dispSlot;
  logic [ENTRIES-1:0]             readyMask;
  logic [ENTRIES-1:0]             freeMask;
  logic [ENTRIES-1:0][SW-1:0]     agesPacked;

  sched_ctrl #(.NUM_REGS(NUM_REGS), .ENTRIES(ENTRIES)) ctrl_i (
    .readyMask   (readyMask),
    .freeMask    (freeMask),
    .agesPacked  (agesPacked),
    .regAvail    (regAvail),
    .wbMask      (wbMask),
    .dispValid   (dispValid),
    .dispDst     (dispDst),
    .dispDstUsed (dispDstUsed),
    .commitValid (commitValid),
    .strobe      (strobe),
    .dispSlot    (dispSlot),
    .issueSlot   (issueSlot),
    .dispReady   (dispReady),
    .issueValid  (issueValid)
  );

  sched_entry_array #(
    .NUM_REGS(NUM_REGS), .ENTRIES(ENTRIES), .ALU_LAT(ALU_LAT), .LOAD_LAT(LOAD_LAT)
  ) array_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .dispSlot     (dispSlot),
    .issueSlot    (issueSlot),
    .commitSlot   (commitSlot),
    .dispOp       (dispOp),
    .dispSrcA     (dispSrcA),
    .dispSrcAUsed (dispSrcAUsed),
    .dispSrcB     (dispSrcB),
    .dispSrcBUsed (dispSrcBUsed),
    .dispDst      (dispDst),
    .dispDstUsed  (dispDstUsed),
    .readyMask    (readyMask),
    .freeMask     (freeMask),
    .agesPacked   (agesPacked),
    .issueOp      (issueOp),
    .issueDst     (issueDst),
    .issueDstUsed (issueDstUsed),
    .wbMask       (wbMask),
    .regAvail     (regAvail)
  );

endmodule

// File: rtl/oo_issue_sched_chk.sv
module oo_issue_sched_chk #(
  parameter int NUM_REGS = 8,
  parameter int ENTRIES  = 4
) (
  input logic                                            clk,
  input logic                                            rstN,
  input logic                                            dispValid,
  input logic [$clog2(NUM_REGS)-1:0]                     dispDst,
  input logic                                            dispDstUsed,
  input logic                                            dispReady,
  input logic                                            issueValid,
  input logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] issueSlot,
  input logic [NUM_REGS-1:0]                             wbMask,
  input logic [NUM_REGS-1:0]                             regAvail
);

  assert_dst_cleared_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispReady && dispDstUsed) |=> !regAvail[$past(dispDst)]);

  assert_broadcast_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((wbMask != '0) && !(dispValid && dispReady && dispDstUsed))
      |=> ((regAvail & $past(wbMask)) == $past(wbMask)));

  assert_no_reissue_R6: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> !(issueValid && issueSlot == $past(issueSlot)));

  assert_waw_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dispDstUsed && !regAvail[dispDst] && !wbMask[dispDst]) |-> !dispReady);

endmodule

bind oo_issue_sched oo_issue_sched_chk #(.NUM_REGS(NUM_REGS), .ENTRIES(ENTRIES)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .dispValid   (dispValid),
  .dispDst     (dispDst),
  .dispDstUsed (dispDstUsed),
  .dispReady   (dispReady),
  .issueValid  (issueValid),
  .issueSlot   (issueSlot),
  .wbMask      (wbMask),
  .regAvail    (regAvail)
);

// File: tb/oo_issue_sched_tb_top.sv
module oo_issue_sched_tb_top;
  import sched_pkg::*;

  localparam int NR = 8;
  localparam int NE = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       dispValid, dispSrcAUsed, dispSrcBUsed, dispDstUsed;
  logic [1:0] dispOp;
  logic [2:0] dispSrcA, dispSrcB, dispDst;
  logic       dispReady, issueValid, issueDstUsed, commitValid;
  logic [1:0] issueSlot, issueOp, commitSlot;
  logic [2:0] issueDst;
  logic [NR-1:0] wbMask, regAvail;

  always #10 clk = ~clk;

  oo_issue_sched dut_i (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispOp(dispOp),
    .dispSrcA(dispSrcA), .dispSrcAUsed(dispSrcAUsed), .dispSrcB(dispSrcB),
    .dispSrcBUsed(dispSrcBUsed), .dispDst(dispDst), .dispDstUsed(dispDstUsed),
    .dispReady(dispReady), .issueValid(issueValid), .issueSlot(issueSlot),
    .issueOp(issueOp), .issueDst(issueDst), .issueDstUsed(issueDstUsed),
    .wbMask(wbMask), .commitValid(commitValid), .commitSlot(commitSlot),
    .regAvail(regAvail)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int         cyc;
    logic [1:0] op;
    logic [2:0] dst;
    string      req;
  } exp_t;
  exp_t expQ[$];

  task automatic chkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(int c, logic [1:0] op, logic [2:0] d, string req);
    exp_t e;
    e.cyc = c; e.op = op; e.dst = d; e.req = req;
    expQ.push_back(e);
  endtask

  // monitor: every issue is compared with the next expected item
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rstN === 1'b1 && issueValid === 1'b1) begin
        if (expQ.size() == 0) begin
          chkEq("R6", "unexpected issue of dst", int'(issueDst), -1);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chkEq(e.req, "issue cycle", cyc, e.cyc);
          chkEq(e.req, "issue dst", int'(issueDst), int'(e.dst));
          chkEq(e.req, "issue op", int'(issueOp), int'(e.op));
        end
      end
    end
  end

  task automatic disp(input logic [1:0] op, input logic [2:0] a, input bit au,
                      input logic [2:0] b, input bit bu, input logic [2:0] d,
                      input bit du, output int k);
    @(negedge clk);
    dispValid = 1'b1; dispOp = op;
    dispSrcA = a; dispSrcAUsed = au; dispSrcB = b; dispSrcBUsed = bu;
    dispDst = d; dispDstUsed = du;
    commitValid = 1'b0;
    k = cyc;
  endtask

  task automatic stopDrive();
    @(negedge clk);
    dispValid = 1'b0;
    commitValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) stopDrive();
  endtask

  task automatic commitOne(int s);
    @(negedge clk);
    dispValid = 1'b0;
    commitValid = 1'b1;
    commitSlot = 2'(s);
  endtask

  task automatic commitAll();
    for (int s = 0; s < NE; s++) commitOne(s);
    stopDrive();
  endtask

  task automatic at(int c);
    while (cyc < c) @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int k, kx;
    rstN = 1'b0;
    dispValid = 0; dispOp = 0; dispSrcA = 0; dispSrcAUsed = 0;
    dispSrcB = 0; dispSrcBUsed = 0; dispDst = 0; dispDstUsed = 0;
    commitValid = 0; commitSlot = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chkEq("R1", "regAvail", int'(regAvail), 255);
    chkEq("R1", "dispReady", int'(dispReady), 1);
    chkEq("R1", "issueValid", int'(issueValid), 0);
    chkEq("R1", "wbMask", int'(wbMask), 0);

    // R3/R2/R5: independent ALU op
    disp(OP_ALU, 3'd1, 1, 3'd0, 0, 3'd2, 1, k);
    push(k + 1, OP_ALU, 3'd2, "R3");
    stopDrive();
    at(k + 1); chkEq("R2", "regAvail[2] after dispatch", int'(regAvail[2]), 0);
    at(k + 2); chkEq("R5", "wbMask ALU", int'(wbMask), 4);
    at(k + 3); chkEq("R5", "regAvail after broadcast", int'(regAvail), 255);
    idle(2); commitAll();

    // R4: dependent ALU chain
    disp(OP_ALU, 3'd0, 0, 3'd0, 0, 3'd3, 1, k);
    push(k + 1, OP_ALU, 3'd3, "R4");
    disp(OP_ALU, 3'd3, 1, 3'd0, 0, 3'd4, 1, kx);
    push(k + 3, OP_ALU, 3'd4, "R4");
    stopDrive();
    idle(4); commitAll();

    // R5/R4: load latency, younger independent op overtakes
    disp(OP_LOAD, 3'd0, 0, 3'd0, 0, 3'd5, 1, k);
    push(k + 1, OP_LOAD, 3'd5, "R5");
    disp(OP_ALU, 3'd5, 1, 3'd0, 0, 3'd6, 1, kx);
    disp(OP_ALU, 3'd0, 0, 3'd0, 0, 3'd7, 1, kx);
    push(k + 3, OP_ALU, 3'd7, "R4");
    push(k + 6, OP_ALU, 3'd6, "R4");
    stopDrive();
    at(k + 4); chkEq("R5", "wbMask before load done", int'(wbMask), 128);
    at(k + 5); chkEq("R5", "wbMask load at issue+4", int'(wbMask), 32);
    idle(3); commitAll();

    // R6: oldest ready wins even from a higher slot
    disp(OP_ALU, 3'd0, 0, 3'd0, 0, 3'd0, 1, k);
    push(k + 1, OP_ALU, 3'd0, "R6");
    disp(OP_LOAD, 3'd0, 0, 3'd0, 0, 3'd1, 1, kx);
    push(k + 2, OP_LOAD, 3'd1, "R6");
    disp(OP_ALU, 3'd1, 1, 3'd0, 0, 3'd2, 1, kx);
    commitOne(0);
    disp(OP_ALU, 3'd0, 0, 3'd1, 1, 3'd3, 1, kx);
    push(k + 7, OP_ALU, 3'd2, "R6");
    push(k + 8, OP_ALU, 3'd3, "R6");
    stopDrive();
    idle(6); commitAll();

    // R9: source broadcast in the dispatch cycle
    disp(OP_ALU, 3'd0, 0, 3'd0, 0, 3'd4, 1, k);
    push(k + 1, OP_ALU, 3'd4, "R9");
    stopDrive();
    disp(OP_ALU, 3'd4, 1, 3'd0, 0, 3'd5, 1, kx);
    push(k + 3, OP_ALU, 3'd5, "R9");
    stopDrive();
    idle(4); commitAll();

    // R8: commits of a not-yet-completed load are ignored
    disp(OP_LOAD, 3'd0, 0, 3'd0, 0, 3'd3, 1, k);
    push(k + 1, OP_LOAD, 3'd3, "R8");
    commitOne(0);
    commitOne(0);
    stopDrive();
    at(k + 5); chkEq("R8", "load still broadcasts", int'(wbMask), 8);
    idle(2); commitAll();

    // R7: write-after-write dispatch held until producer broadcasts
    disp(OP_LOAD, 3'd0, 0, 3'd0, 0, 3'd2, 1, k);
    push(k + 1, OP_LOAD, 3'd2, "R7");
    push(k + 6, OP_ALU, 3'd2, "R7");
    for (int j = 1; j <= 5; j++) begin
      @(negedge clk);
      dispValid = 1'b1; dispOp = OP_ALU; dispSrcAUsed = 0; dispSrcBUsed = 0;
      dispDst = 3'd2; dispDstUsed = 1'b1;
      #1;
      chkEq("R7", "dispReady during WAW", int'(dispReady), (j == 5) ? 1 : 0);
    end
    stopDrive();
    at(k + 6); chkEq("R2", "clear wins over same-cycle set", int'(regAvail[2]), 0);
    idle(3); commitAll();

    // R10/R7: opcode encodings, then full station
    disp(OP_BRANCH, 3'd1, 1, 3'd2, 1, 3'd0, 0, k);
    push(k + 1, OP_BRANCH, 3'd0, "R10");
    disp(OP_SPARE, 3'd0, 0, 3'd0, 0, 3'd6, 1, kx);
    push(k + 2, OP_SPARE, 3'd6, "R10");
    disp(OP_BRANCH, 3'd0, 0, 3'd0, 0, 3'd0, 0, kx);
    push(k + 3, OP_BRANCH, 3'd0, "R10");
    #1; chkEq("R10", "branch has no broadcast", int'(wbMask), 0);
    disp(OP_BRANCH, 3'd0, 0, 3'd0, 0, 3'd0, 0, kx);
    push(k + 4, OP_BRANCH, 3'd0, "R10");
    #1; chkEq("R10", "opcode 3 latency 1", int'(wbMask), 64);
    disp(OP_ALU, 3'd0, 0, 3'd0, 0, 3'd5, 1, kx);
    #1; chkEq("R7", "dispReady when full", int'(dispReady), 0);
    stopDrive();
    at(k + 6); chkEq("R7", "stalled dispatch left scoreboard", int'(regAvail), 255);
    commitAll();
    #1; chkEq("R8", "dispReady after commits", int'(dispReady), 1);

    idle(3);
    chkEq("R4", "pending expected issues", expQ.size(), 0);
    done = 1;
    summary();
    $finish;
  end

endmodule